// File: doc/BRIEF.md
# Edge-Triggered External Interrupt and Wake-Up Controller

This block collects a parameterised number of asynchronous input lines and turns their edges into interrupt requests and wake-up events. Each line is first brought into the clock domain by a two-stage synchronizer. A one-cycle edge strobe is then derived from the synchronized value and the value one cycle older. Software picks, per line, whether rising edges, falling edges, both or neither count. A counted edge latches a pending flag for that line whether or not the line's interrupt is enabled. One combined request output is raised while any pending line has its interrupt enabled.

Separately, any line may be marked as a wake-up source. A counted edge on such a line gives a single-cycle pulse on that line's own event output. Software can force a line pending through a trigger register, and clears pending flags by writing ones to them. Register storage exists only for the implemented lines. Higher bits ignore writes and read as zero, so software can find the line count by writing all ones to the rising-edge register and locating the highest bit that reads back as one.

The block sits on a simple single-cycle 32-bit register bus. Writes take effect at the clock edge while select and write are both high. Read data is combinational from the address while select is high and write is low, and is zero otherwise.

Top module: `eic_top`

## Requirements
- R1: The word registers sit at these byte offsets: 0x00 interrupt enable, 0x04 wake enable, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending. Each reads back independently, all reset to zero, and every other offset reads zero.
- R2: With only the rising-select bit set, a 0-to-1 transition of the line sets its pending bit and a 1-to-0 transition does not.
- R3: With only the falling-select bit set, a 1-to-0 transition sets the pending bit and a 0-to-1 transition does not.
- R4: With both select bits set, either transition sets the pending bit.
- R5: With neither select bit set, transitions of the line leave the pending bit at zero.
- R6: A counted edge sets the pending bit even when the interrupt-enable bit is 0. The request output `irqOut` is 1 exactly when some line has both its pending bit and its interrupt-enable bit at 1, so writing the enable bit to 1 later raises `irqOut`.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R8: When a line's wake-enable bit is 1, a counted edge gives a pulse of exactly one cycle on that line's `wakeEvt` bit. When the bit is 0, no pulse appears.
- R9: Writing 1 to a software-trigger bit sets the same pending bit and the trigger bit, which reads back as 1. The trigger bit returns to 0 when that pending bit is cleared by a write of 1.
- R10: When a counted edge and a write-1 clear hit the same pending bit at the same clock edge, the bit stays 1.
- R11: Bits at or above the line count ignore writes and read as 0 in every register. After all ones are written to rising select, the readback is 2^LINES-1.
- R12: An input transition applied between clock edges shows on `wakeEvt` in the cycle after the second rising clock edge. It sets the pending bit, and raises `irqOut` if enabled, at the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when not reading |
| lineIn | input | LINES | Asynchronous input lines |
| irqOut | output | 1 | Combined interrupt request |
| wakeEvt | output | LINES | Per-line one-cycle wake-up event pulses |

## Verification
The bench builds the block with LINES set to 12, well below the 32-bit word. This puts unimplemented bits in every register within reach, so the all-ones probe must return exactly twelve lines. A vector table walks every combination of the two select bits against both transition directions on one line. Directed tests then time the synchronizer latency cycle by cycle on the event pulse and the request. They also line up an edge with a clearing write at the same clock edge, and follow the software trigger bit through set and clear.

// File: rtl/eic_pkg.sv
package eic_pkg;

  typedef enum logic [2:0] {
    SEL_INTEN  = 3'd0,
    SEL_WAKE   = 3'd1,
    SEL_RISE   = 3'd2,
    SEL_FALL   = 3'd3,
    SEL_SWTRIG = 3'd4,
    SEL_PEND   = 3'd5,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrIntEn;
    logic    wrWake;
    logic    wrRise;
    logic    wrFall;
    logic    wrSwTrig;
    logic    wrPend;
    regSel_e rdSel;
  } eicStrobe_t;

endpackage

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output eicStrobe_t        strb
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             unusedAddr;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign unusedAddr = ^busAddr[1:0];

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    if (busSel && busWrite) begin
      case (wordIdx)
        IDX_W'(0): strb.wrIntEn  = 1'b1;
        IDX_W'(1): strb.wrWake   = 1'b1;
        IDX_W'(2): strb.wrRise   = 1'b1;
        IDX_W'(3): strb.wrFall   = 1'b1;
        IDX_W'(4): strb.wrSwTrig = 1'b1;
        IDX_W'(5): strb.wrPend   = 1'b1;
        default:   ;
      endcase
    end else if (busSel) begin
      case (wordIdx)
        IDX_W'(0): strb.rdSel = SEL_INTEN;
        IDX_W'(1): strb.rdSel = SEL_WAKE;
        IDX_W'(2): strb.rdSel = SEL_RISE;
        IDX_W'(3): strb.rdSel = SEL_FALL;
        IDX_W'(4): strb.rdSel = SEL_SWTRIG;
        IDX_W'(5): strb.rdSel = SEL_PEND;
        default:   strb.rdSel = SEL_NONE;
      endcase
    end
  end

  // R1
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrIntEn, strb.wrWake, strb.wrRise, strb.wrFall, strb.wrSwTrig, strb.wrPend}));

  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|{strb.wrIntEn, strb.wrWake, strb.wrRise, strb.wrFall, strb.wrSwTrig, strb.wrPend})
      |-> (strb.rdSel == SEL_NONE));

endmodule

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
#(
  parameter int LINES  = 23,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  eicStrobe_t        strb,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  lineIn,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic [LINES-1:0]  wakeEvt
);

  logic [LINES-1:0] syncA, syncB, prevQ;
  logic [LINES-1:0] riseStb, fallStb, edgeHit;
  logic [LINES-1:0] intEnQ, wakeQ, riseSelQ, fallSelQ, swTrigQ, pendQ;
  logic [LINES-1:0] swSet, pendClr;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= 1'b0;
        syncB[i] <= 1'b0;
        prevQ[i] <= 1'b0;
      end else begin
        syncA[i] <= lineIn[i];
        syncB[i] <= syncA[i];
        prevQ[i] <= syncB[i];
      end
    end
    assign riseStb[i] = syncB[i] & ~prevQ[i];
    assign fallStb[i] = ~syncB[i] & prevQ[i];
  end

  assign edgeHit = (riseStb & riseSelQ) | (fallStb & fallSelQ);
  assign swSet   = strb.wrSwTrig ? wdata : '0;
  assign pendClr = strb.wrPend ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnQ   <= '0;
      wakeQ    <= '0;
      riseSelQ <= '0;
      fallSelQ <= '0;
      swTrigQ  <= '0;
      pendQ    <= '0;
    end else begin
      if (strb.wrIntEn) intEnQ   <= wdata;
      if (strb.wrWake)  wakeQ    <= wdata;
      if (strb.wrRise)  riseSelQ <= wdata;
      if (strb.wrFall)  fallSelQ <= wdata;
      swTrigQ <= (swTrigQ | swSet) & ~pendClr;
      pendQ   <= (pendQ & ~pendClr) | edgeHit | swSet;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_INTEN:  rdata = DATA_W'(intEnQ);
      SEL_WAKE:   rdata = DATA_W'(wakeQ);
      SEL_RISE:   rdata = DATA_W'(riseSelQ);
      SEL_FALL:   rdata = DATA_W'(fallSelQ);
      SEL_SWTRIG: rdata = DATA_W'(swTrigQ);
      SEL_PEND:   rdata = DATA_W'(pendQ);
      default:    rdata = '0;
    endcase
  end

  assign irqOut  = |(pendQ & intEnQ);
  assign wakeEvt = edgeHit & wakeQ;

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(edgeHit)) == $past(edgeHit)));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPend |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R10
  clear_lose_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPend |=> ((pendQ & $past(wdata & ~edgeHit)) == '0));

  // R9
  sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSwTrig |=> ((pendQ & $past(wdata)) == $past(wdata)));

  // R8
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((wakeEvt & $past(wakeEvt)) == '0));

endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int LINES  = 23,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [LINES-1:0]  lineIn,
  output logic              irqOut,
  output logic [LINES-1:0]  wakeEvt
);

  localparam int DATA_W = 32;

  eicStrobe_t strb;
  logic       unusedWdata;

  assign unusedWdata = ^busWdata;

  eic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  eic_datapath #(.LINES(LINES), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata[LINES-1:0]),
    .lineIn  (lineIn),
    .rdata   (busRdata),
    .irqOut  (irqOut),
    .wakeEvt (wakeEvt)
  );

endmodule

// File: tb/sim_eic_top.sv
module sim_eic_top;

  localparam int NL = 12;
  localparam logic [4:0] A_INTEN = 5'h00, A_WAKE = 5'h04, A_RISE = 5'h08,
                         A_FALL = 5'h0C, A_SWTRIG = 5'h10, A_PEND = 5'h14;

  // fields: [4] rise sel, [3] fall sel, [2] start level, [1] end level, [0] expected pending
  localparam logic [4:0] VEC [7] = '{
    5'b10011,  // R2 rising only, 0->1
    5'b10100,  // R2 rising only, 1->0
    5'b01101,  // R3 falling only, 1->0
    5'b01010,  // R3 falling only, 0->1
    5'b11011,  // R4 both, 0->1
    5'b11101,  // R4 both, 1->0
    5'b00010   // R5 neither, 0->1
  };
  localparam int VREQ [7] = '{2, 2, 3, 3, 4, 4, 5};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] lineIn = '0;
  logic          irqOut;
  logic [NL-1:0] wakeEvt;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  eic_top #(.LINES(NL), .ADDR_W(5)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .lineIn(lineIn), .irqOut(irqOut), .wakeEvt(wakeEvt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state of every register and outputs
    for (int r = 0; r < 6; r++) begin
      rd(5'(r * 4), rv);
      chk(rv == 32'h0, "R1 reset value", rv, 32'h0);
    end
    chk(irqOut == 1'b0, "R1 reset irqOut", {31'h0, irqOut}, 32'h0);
    chk(wakeEvt == '0, "R1 reset wakeEvt", 32'(wakeEvt), 32'h0);

    // R1 independent registers at their offsets
    wr(A_INTEN, 32'h0A5A);
    wr(A_WAKE, 32'h05A5);
    wr(A_RISE, 32'h0333);
    wr(A_FALL, 32'h0CCC);
    rd(A_INTEN, rv); chk(rv == 32'h0A5A, "R1 interrupt enable", rv, 32'h0A5A);
    rd(A_WAKE, rv);  chk(rv == 32'h05A5, "R1 wake enable", rv, 32'h05A5);
    rd(A_RISE, rv);  chk(rv == 32'h0333, "R1 rising select", rv, 32'h0333);
    rd(A_FALL, rv);  chk(rv == 32'h0CCC, "R1 falling select", rv, 32'h0CCC);
    rd(5'h18, rv);   chk(rv == 32'h0, "R1 unmapped offset", rv, 32'h0);

    // R11 unimplemented bits and line-count probe
    wr(A_RISE, 32'hFFFF_FFFF);
    rd(A_RISE, rv);
    chk(rv == 32'h0000_0FFF, "R11 rising readback", rv, 32'h0000_0FFF);
    begin
      int cnt = 0;
      for (int b = 0; b < 32; b++) if (rv[b]) cnt = b + 1;
      chk(cnt == NL, "R11 probed line count", 32'(cnt), 32'(NL));
    end
    wr(A_INTEN, 32'hFFFF_F000);
    rd(A_INTEN, rv);
    chk(rv == 32'h0, "R11 upper bits ignored", rv, 32'h0);

    wr(A_INTEN, 32'h0);
    wr(A_WAKE, 32'h0);
    wr(A_RISE, 32'h0);
    wr(A_FALL, 32'h0);

    // vector walk over edge selection on line 3
    for (int v = 0; v < 7; v++) begin
      wr(A_RISE, VEC[v][4] ? 32'h8 : 32'h0);
      wr(A_FALL, VEC[v][3] ? 32'h8 : 32'h0);
      lineIn[3] = VEC[v][2];
      idle(5);
      wr(A_PEND, 32'hFFFF_FFFF);
      lineIn[3] = VEC[v][1];
      idle(5);
      rd(A_PEND, rv);
      chk(rv == {28'h0, VEC[v][0], 3'b000}, $sformatf("R%0d edge vector %0d", VREQ[v], v),
          rv, {28'h0, VEC[v][0], 3'b000});
    end

    // R6 masked line still goes pending; enabling raises the request
    wr(A_RISE, 32'h8);
    wr(A_FALL, 32'h0);
    lineIn[3] = 1'b0;
    idle(5);
    wr(A_PEND, 32'hFFFF_FFFF);
    lineIn[3] = 1'b1;
    idle(5);
    chk(irqOut == 1'b0, "R6 masked request", {31'h0, irqOut}, 32'h0);
    rd(A_PEND, rv);
    chk(rv == 32'h8, "R6 masked pending", rv, 32'h8);
    wr(A_INTEN, 32'h8);
    chk(irqOut == 1'b1, "R6 enabled request", {31'h0, irqOut}, 32'h1);

    // R7 write zero keeps, write one clears
    wr(A_PEND, 32'h0);
    rd(A_PEND, rv);
    chk(rv == 32'h8, "R7 write zero keeps", rv, 32'h8);
    wr(A_PEND, 32'h8);
    rd(A_PEND, rv);
    chk(rv == 32'h0, "R7 write one clears", rv, 32'h0);
    chk(irqOut == 1'b0, "R7 request drops", {31'h0, irqOut}, 32'h0);

    // R9 software trigger
    wr(A_SWTRIG, 32'h80);
    rd(A_PEND, rv);   chk(rv == 32'h80, "R9 trigger sets pending", rv, 32'h80);
    rd(A_SWTRIG, rv); chk(rv == 32'h80, "R9 trigger readback", rv, 32'h80);
    wr(A_PEND, 32'h80);
    rd(A_PEND, rv);   chk(rv == 32'h0, "R9 pending cleared", rv, 32'h0);
    rd(A_SWTRIG, rv); chk(rv == 32'h0, "R9 trigger self-clears", rv, 32'h0);

    // R10 edge and clear at the same clock edge
    wr(A_INTEN, 32'h0);
    lineIn[3] = 1'b0;
    idle(5);
    wr(A_SWTRIG, 32'h8);
    @(negedge clk);
    lineIn[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = A_PEND; busWdata = 32'h8;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    rd(A_PEND, rv);
    chk(rv == 32'h8, "R10 set wins over clear", rv, 32'h8);
    wr(A_PEND, 32'hFFFF_FFFF);

    // R12 and R8 latency and single-cycle wake pulse on line 5
    wr(A_RISE, 32'h20);
    wr(A_FALL, 32'h0);
    wr(A_INTEN, 32'h20);
    wr(A_WAKE, 32'h20);
    wr(A_PEND, 32'hFFFF_FFFF);
    lineIn[5] = 1'b1;
    @(posedge clk);
    #1 chk(wakeEvt[5] == 1'b0, "R12 no pulse after first edge", 32'(wakeEvt), 32'h0);
    @(posedge clk);
    #1 chk(wakeEvt == 12'h020, "R8 wake pulse", 32'(wakeEvt), 32'h20);
    chk(irqOut == 1'b0, "R12 request not yet", {31'h0, irqOut}, 32'h0);
    @(posedge clk);
    #1 chk(wakeEvt == '0, "R8 pulse one cycle", 32'(wakeEvt), 32'h0);
    chk(irqOut == 1'b1, "R12 request at third edge", {31'h0, irqOut}, 32'h1);

    // R8 no pulse when wake disabled
    wr(A_WAKE, 32'h0);
    wr(A_FALL, 32'h20);
    wr(A_PEND, 32'hFFFF_FFFF);
    lineIn[5] = 1'b0;
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(posedge clk);
        #1 if (wakeEvt != '0) seen = 1'b1;
      end
      chk(seen == 1'b0, "R8 disabled wake silent", {31'h0, seen}, 32'h0);
    end
    rd(A_PEND, rv);
    chk(rv == 32'h20, "R3 falling pending line 5", rv, 32'h20);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule